// File: doc/BRIEF.md
# Escaped Run-Length Hex Encoder

This block compresses a stream of 4-bit hexadecimal digits without loss. Symbols enter one per valid/ready handshake, and the final symbol of a stream carries an end-of-stream flag. The output is another nibble stream with its own valid/ready handshake. The final nibble of that stream is flagged as end of stream.

A run of equal digits that reaches a minimum length is replaced by a four-nibble group. The group is the escape digit, then the repeated digit, then the run length as two hex digits with the high digit first. Shorter runs are copied through unchanged. The escape digit itself is never copied through. Every run of it is written as a group, so a decoder always reads the escape digit as the start of a group.

Input is held off while a group is being written out. Because of this, output back-pressure reaches the source and no symbol is lost.

Top module: `rle_hex_enc`

## Requirements
- R1: After reset, out_valid is low and in_ready is high, and no output appears until a symbol has been accepted.
- R2: A compressed run is four nibbles, in this order: escape digit 4'hA, the repeated digit, the count bits [7:4], then the count bits [3:0].
- R3: A run of 4 or more equal non-escape digits is compressed. A run of 1 to 3 such digits is copied unchanged, one output nibble per input digit.
- R4: Every run of digit 4'hA is compressed, including a run of length 1 (output A A 0 1).
- R5: A run longer than 255 is split. It becomes groups of count 255, followed by a remainder that follows R3 or R4.
- R6: On the input end-of-stream flag, the pending run is flushed. out_last is high only on the final output nibble of the stream, and out_valid is low once that nibble is taken.
- R7: While out_valid is high and out_ready is low, out_data and out_last hold their values and out_valid stays high.
- R8: in_ready is low whenever out_valid is high. Every accepted symbol is represented in the output in order.
- R9: The input 20×0, 2×F, 17×0, 3×A, 8×F encodes to A014FFA011AA03AF08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Encoder can take a symbol |
| in_data | input | 4 | Input hex digit |
| in_last | input | 1 | Marks the final symbol of a stream |
| out_valid | output | 1 | Output nibble valid |
| out_ready | input | 1 | Sink takes the output nibble |
| out_data | output | 4 | Output nibble |
| out_last | output | 1 | Marks the final output nibble of a stream |

## Verification
Two things can fall in the same cycle: an arriving symbol that closes the current run (a new digit, or a run reaching 255), and the end-of-stream flag. The block then has to emit the old run and then flush the new one-symbol run as a second group. The bench provokes this with streams whose final digit differs from the one before, with single escape digits at the end, and with runs that end exactly at 255 or 256. Random output stalls are applied throughout. Each case is judged by comparing the whole output, and the position of out_last, against a model computed in the bench.

// File: rtl/rle_hex_enc.sv
module rle_hex_enc #(
  parameter int SYM_W = 4,
  parameter logic [SYM_W-1:0] ESC = 4'hA,
  parameter int MIN_RUN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_data,
  output logic             out_last
);
  localparam int CNT_W = 2 * SYM_W;
  localparam logic [CNT_W-1:0] MAX_C = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_RUN);
  localparam logic [CNT_W-1:0] GRP_C = CNT_W'(4);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic             run_on, flush_pend;
  logic [SYM_W-1:0] run_sym;
  logic [CNT_W-1:0] run_cnt;
  logic             busy, e_enc, e_last;
  logic [SYM_W-1:0] e_sym;
  logic [CNT_W-1:0] e_cnt, e_idx, e_len;

  wire in_fire   = in_valid && in_ready;
  wire out_fire  = busy && out_ready;
  wire same      = run_on && (in_data == run_sym) && (run_cnt != MAX_C);
  wire load_old  = in_fire && run_on && !same;
  wire load_fin  = !busy && flush_pend;
  wire grp_done  = e_idx == e_len - ONE_C;

  assign in_ready  = !busy && !flush_pend;
  assign out_valid = busy;
  assign e_len     = e_enc ? GRP_C : e_cnt;
  assign out_last  = busy && e_last && grp_done;

  always_comb begin
    out_data = e_sym;
    if (e_enc) begin
      case (e_idx)
        CNT_W'(0): out_data = ESC;
        CNT_W'(1): out_data = e_sym;
        CNT_W'(2): out_data = e_cnt[CNT_W-1:SYM_W];
        default:   out_data = e_cnt[SYM_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_on <= 1'b0; flush_pend <= 1'b0; run_sym <= '0; run_cnt <= '0;
      busy <= 1'b0; e_enc <= 1'b0; e_last <= 1'b0;
      e_sym <= '0; e_cnt <= '0; e_idx <= '0;
    end else begin
      if (out_fire) begin
        if (grp_done) busy <= 1'b0;
        else e_idx <= e_idx + ONE_C;
      end
      if (in_fire) begin
        if (same) run_cnt <= run_cnt + ONE_C;
        else begin
          run_sym <= in_data;
          run_cnt <= ONE_C;
          run_on  <= 1'b1;
        end
        if (in_last) flush_pend <= 1'b1;
      end
      if (load_old || load_fin) begin
        busy   <= 1'b1;
        e_idx  <= '0;
        e_sym  <= run_sym;
        e_cnt  <= run_cnt;
        e_enc  <= (run_cnt >= MIN_C) || (run_sym == ESC);
        e_last <= load_fin;
      end
      if (load_fin) begin
        run_on     <= 1'b0;
        flush_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rle_hex_enc_chk.sv
module rle_hex_enc_chk #(
  parameter int SYM_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [SYM_W-1:0] out_data,
  input logic             out_last
);
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r8_no_accept_while_emitting: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r6_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

bind rle_hex_enc rle_hex_enc_chk #(.SYM_W(SYM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/tb_rle_hex_enc.sv
module tb_rle_hex_enc;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [3:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [3:0] out_data;

  always #10 clk = ~clk;

  rle_hex_enc dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int errors = 0, checks = 0;
  logic [3:0] stim [0:2047];
  int slen;
  logic [3:0] expv [0:4095];
  int en;
  logic [3:0] got [0:4095];
  int gn, last_at, last_cnt;
  bit stall_rdy, gaps;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void push(input logic [3:0] v);
    expv[en] = v; en++;
  endfunction

  function automatic void model();
    int i = 0;
    en = 0;
    while (i < slen) begin
      logic [3:0] s = stim[i];
      int n = 1;
      while (i + n < slen && stim[i+n] == s && n < 255) n++;
      if (n >= 4 || s == 4'hA) begin
        push(4'hA); push(s); push(4'(n >> 4)); push(4'(n & 15));
      end else
        for (int k = 0; k < n; k++) push(s);
      i += n;
    end
  endfunction

  function automatic void add_run(input logic [3:0] s, input int n);
    for (int k = 0; k < n; k++) begin stim[slen] = s; slen++; end
  endfunction

  // output monitor, with stall and input-block checks
  initial begin
    bit held = 0;
    logic [3:0] hd;
    logic hl;
    forever begin
      @(negedge clk);
      out_ready = stall_rdy ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (rst_n) begin
        if (held && out_valid)
          chk(out_data == hd && out_last == hl, "R7", "held nibble", int'(out_data), int'(hd));
        else if (held)
          chk(0, "R7", "valid dropped during stall", 0, 1);
        held = out_valid && !out_ready;
        hd = out_data; hl = out_last;
        if (out_valid && in_ready) chk(0, "R8", "in_ready while emitting", 1, 0);
        if (out_valid && out_ready) begin
          if (gn < 4096) got[gn] = out_data;
          if (out_last) begin last_at = gn; last_cnt++; end
          gn++;
        end
      end
    end
  end

  task automatic run_case(input string req);
    int w = 0;
    gn = 0; last_at = -1; last_cnt = 0;
    for (int i = 0; i < slen; i++) begin
      bit acc;
      if (gaps && $urandom % 5 == 0) begin in_valid = 1'b0; @(negedge clk); end
      in_valid = 1'b1; in_data = stim[i]; in_last = (i == slen - 1);
      do begin #2; acc = in_ready; @(negedge clk); end while (!acc);
    end
    in_valid = 1'b0; in_last = 1'b0;
    while (last_at < 0 && w < 20000) begin @(negedge clk); w++; end
    repeat (8) @(negedge clk);
    model();
    chk(gn == en, req, "output length", gn, en);
    begin
      int bad = -1;
      for (int k = 0; k < en && k < gn; k++) if (bad < 0 && got[k] != expv[k]) bad = k;
      if (bad >= 0) chk(0, req, $sformatf("nibble %0d", bad), int'(got[bad]), int'(expv[bad]));
      else chk(1, req, "content", 0, 0);
    end
    chk(last_at == en - 1 && last_cnt == 1, "R6", "out_last position", last_at, en - 1);
  endtask

  initial begin
    #(20 * 190000);
    chk(0, "WATCHDOG", "timeout", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    stall_rdy = 0; gaps = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R1", "out_valid idle", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready idle", int'(in_ready), 1);

    // R9 reference vector, also R2 layout
    slen = 0; add_run(4'h0, 20); add_run(4'hF, 2); add_run(4'h0, 17);
    add_run(4'hA, 3); add_run(4'hF, 8);
    run_case("R9");
    chk(en == 18 && expv[0] == 4'hA && expv[3] == 4'h4, "R2", "model sanity", en, 18);

    slen = 0; add_run(4'hA, 1); run_case("R4");
    slen = 0; add_run(4'h5, 3); add_run(4'h6, 4); add_run(4'hA, 2); add_run(4'h5, 1); run_case("R3");
    slen = 0; add_run(4'h1, 4); add_run(4'h2, 1); run_case("R6");
    slen = 0; add_run(4'h7, 255); run_case("R5");
    slen = 0; add_run(4'h7, 256); run_case("R5");
    slen = 0; add_run(4'h7, 259); run_case("R5");
    slen = 0; add_run(4'hA, 257); add_run(4'h3, 2); run_case("R5");

    stall_rdy = 1; gaps = 1;
    slen = 0; add_run(4'h9, 300); add_run(4'hA, 1); run_case("R8");
    for (int t = 0; t < 25; t++) begin
      int target = 20 + $urandom % 400;
      slen = 0;
      while (slen < target) begin
        logic [3:0] s = ($urandom % 4 == 0) ? 4'hA : 4'($urandom % 16);
        int n = ($urandom % 10 == 0) ? 1 + $urandom % 300 : 1 + $urandom % 6;
        if (slen + n > 1500) n = 1;
        add_run(s, n);
      end
      run_case("R8");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule